// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

The block keeps wall-clock time and calendar date in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year with a century flag. A reference enable that pulses at 32768 Hz feeds a prescaler. Each time the prescaler fills, it advances the seconds, and the carries ripple up through the calendar within the same clock cycle. The hours register runs in either 24-hour or 12-hour form, chosen by a mode bit held in the register itself.

The host reaches the registers through a byte port with an auto-incrementing pointer. A start strobe loads the pointer and freezes a snapshot of all seven registers. Each read or write then moves the pointer one step, wrapping from the year back to the seconds. All reads in a burst come from the snapshot, so a tick in the middle of the burst cannot give torn values. Writes go straight to the live counters. Every write also restarts the prescaler, so the next increment comes one full second after the write.

Top module: `rtc_bcd_core`

## Requirements
- R1: Register index 0..6 selects seconds, minutes, hours, day of week, date, month, year. Unused bits read as 0. After reset the seven bytes read 00, 00, 00, 01, 01, 01, 00.
- R2: Seconds advance once per PRESCALE reference enables. A write restarts the prescaler, so the next increment needs a full PRESCALE enables after the write.
- R3: Seconds and minutes wrap from 59 to 00, and each wrap carries into the next field in the same cycle.
- R4: In 24-hour mode (hours bit 6 = 0, hour in bits 5:0), hour 23 wraps to 00 and advances both the day of week and the date in that same cycle.
- R5: In 12-hour mode (hours bit 6 = 1, bit 5 = PM, hour in bits 4:0) the hour runs 12, 01, ..., 11. Moving from 11 to 12 flips PM. 12 AM is midnight and 12 PM is noon. Only 11 PM to 12 AM advances the day. The mode bit is kept through increments.
- R6: The day of week counts 1..7 and wraps from 7 to 1. A written 0 is stored as 1.
- R7: The date wraps to 01 after the last day of the month: 31, or 30 for April, June, September and November. February ends on 29 when the two-digit year is divisible by 4, and on 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and toggles the century flag (month bit 7).
- R9: A start strobe loads the pointer from the address. Each read or write strobe advances the pointer, and index 6 is followed by index 0.
- R10: Reads within a burst return the register values as they stood at the start strobe, even if a second elapses during the burst.
- R11: If a write lands in the same cycle that would complete a second, the written value is kept, nothing increments in that cycle, and the next increment follows PRESCALE enables later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | 32768 Hz reference enable, one cycle per reference period |
| start_i | input | 1 | Burst start: load pointer, take snapshot |
| addr_i | input | 3 | Start index for the pointer |
| wr_i | input | 1 | Write strobe at pointer, then advance |
| rd_i | input | 1 | Read advance strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Snapshot byte at pointer |

## Verification
The interesting coincidence is a host write landing on the very cycle in which the prescaler would complete a second. The bench gates the reference enable so it can count enables exactly. It brings the prescaler to one enable short of the period, then drives a write and the final enable together. It expects the written seconds value unchanged, no increment after one enable short of a fresh period, and exactly one increment after the next. A second case lets a full second elapse between the snapshot read of the seconds and the read of the minutes, at a minute boundary, and expects the pre-tick minute from the burst.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_REGS = 7;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;  // [6] 12h mode, [5] PM or tens-of-twenty
    logic [2:0] dow;
    logic [5:0] date;
    logic       cent;
    logic [4:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_leap(input logic [7:0] y);
    logic [7:0] b;
    b = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] reg_byte(input rtc_time_t t, input logic [ADDR_W-1:0] idx);
    case (idx)
      A_SEC:   return {1'b0, t.sec};
      A_MIN:   return {1'b0, t.min};
      A_HOUR:  return {1'b0, t.hour};
      A_DOW:   return {5'b0, t.dow};
      A_DATE:  return {2'b0, t.date};
      A_MON:   return {t.cent, 2'b0, t.mon};
      A_YEAR:  return t.year;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic clr_i,
  output logic sec_tick_o
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;

  assign sec_tick_o = ref_tick_i & ~clr_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (ref_tick_i)  cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ref_tick_i) |=> $stable(cnt_q));
  p_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wdata_i,
  output rtc_time_t         time_o
);
  rtc_time_t cur_q, nxt;
  logic c_min, c_hr, c_day, c_mon, c_yr;
  logic [4:0] h12;
  logic       pm;

  assign h12 = cur_q.hour[4:0];
  assign pm  = cur_q.hour[5];

  always_comb begin
    nxt   = cur_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (sec_tick_i) begin
      if (cur_q.sec == 7'h59) begin
        nxt.sec = '0;
        c_min   = 1'b1;
      end else nxt.sec = 7'(bcd_inc({1'b0, cur_q.sec}));
    end
    if (c_min) begin
      if (cur_q.min == 7'h59) begin
        nxt.min = '0;
        c_hr    = 1'b1;
      end else nxt.min = 7'(bcd_inc({1'b0, cur_q.min}));
    end
    if (c_hr) begin
      if (cur_q.hour[6]) begin
        if (h12 == 5'h11) begin
          nxt.hour = {1'b1, ~pm, 5'h12};
          c_day    = pm;
        end else if (h12 == 5'h12) nxt.hour = {1'b1, pm, 5'h01};
        else nxt.hour = {1'b1, pm, 5'(bcd_inc({3'b0, h12}))};
      end else begin
        if (cur_q.hour[5:0] == 6'h23) begin
          nxt.hour = '0;
          c_day    = 1'b1;
        end else nxt.hour = {1'b0, 6'(bcd_inc({2'b0, cur_q.hour[5:0]}))};
      end
    end
    if (c_day) begin
      nxt.dow = (cur_q.dow == 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
      if (cur_q.date == last_date(cur_q.mon, year_leap(cur_q.year))) begin
        nxt.date = 6'h01;
        c_mon    = 1'b1;
      end else nxt.date = 6'(bcd_inc({2'b0, cur_q.date}));
    end
    if (c_mon) begin
      if (cur_q.mon == 5'h12) begin
        nxt.mon = 5'h01;
        c_yr    = 1'b1;
      end else nxt.mon = 5'(bcd_inc({3'b0, cur_q.mon}));
    end
    if (c_yr) begin
      if (cur_q.year == 8'h99) begin
        nxt.year = 8'h00;
        nxt.cent = ~cur_q.cent;
      end else nxt.year = bcd_inc(cur_q.year);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      cur_q.dow  <= 3'd1;
      cur_q.date <= 6'h01;
      cur_q.mon  <= 5'h01;
    end else if (wr_i) begin
      case (wr_addr_i)
        A_SEC:  cur_q.sec  <= wdata_i[6:0];
        A_MIN:  cur_q.min  <= wdata_i[6:0];
        A_HOUR: cur_q.hour <= wdata_i[6:0];
        A_DOW:  cur_q.dow  <= (wdata_i[2:0] == 3'd0) ? 3'd1 : wdata_i[2:0];
        A_DATE: cur_q.date <= wdata_i[5:0];
        A_MON: begin
          cur_q.cent <= wdata_i[7];
          cur_q.mon  <= wdata_i[4:0];
        end
        A_YEAR: cur_q.year <= wdata_i;
        default: ;
      endcase
    end else begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;

  p_dow_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q.dow != 3'd0);
  p_sec_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !wr_i && cur_q.sec == 7'h59) |=> (cur_q.sec == 7'h00));
  p_day_with_date_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_day && !wr_i) |=> (cur_q.dow != $past(cur_q.dow) && cur_q.date != $past(cur_q.date)));
  p_noon_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_hr && !wr_i && cur_q.hour == 7'h51) |=> (cur_q.hour == 7'h72 && $stable(cur_q.dow)));
  p_mode_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (cur_q.hour[6] == $past(cur_q.hour[6])));
  p_century_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_yr && !wr_i && cur_q.year == 8'h99) |=> (cur_q.cent != $past(cur_q.cent)));
  p_no_tick_on_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_addr_i != A_SEC) |=> $stable(cur_q.sec));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  rtc_time_t         live_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        snap_q [NUM_REGS];

  assign wr_o  = wr_i & ~start_i;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (start_i)         ptr_q <= (addr_i > LAST) ? '0 : addr_i;
    else if (wr_i || rd_i)    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      snap_q[g] <= '0;
      else if (start_i) snap_q[g] <= reg_byte(live_i, ADDR_W'(g));
    end

    p_snap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_i |=> $stable(snap_q[g]));
  end

  assign rdata_o = (ptr_q <= LAST) ? snap_q[ptr_q] : 8'h00;

  p_ptr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
  p_ptr_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && (wr_i || rd_i) && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  input  logic       start_i,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic              sec_tick;
  logic              wr_acc;
  logic [ADDR_W-1:0] ptr;
  rtc_time_t         live;

  rtc_regport u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .live_i  (live),
    .wr_o    (wr_acc),
    .ptr_o   (ptr),
    .rdata_o (rdata_o)
  );

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .clr_i      (wr_acc),
    .sec_tick_o (sec_tick)
  );

  rtc_calendar u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick),
    .wr_i       (wr_acc),
    .wr_addr_i  (ptr),
    .wdata_i    (wdata_i),
    .time_o     (live)
  );
endmodule

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0, start = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] rb [7];
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_bcd_core #(.PRESCALE(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .start_i(start),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic op_start(input logic [2:0] a);
    @(negedge clk); start = 1'b1; addr = a;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic op_wr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic op_rd_next(output logic [7:0] v);
    @(negedge clk); v = rdata; rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
    end
    @(negedge clk); ref_tick = 1'b0;
  endtask

  task automatic read_all();
    op_start(3'd0);
    for (int i = 0; i < 7; i++) op_rd_next(rb[i]);
  endtask

  task automatic set7(input logic [7:0] s, m, h, d, dt, mo, y);
    op_start(3'd0);
    op_wr(s); op_wr(m); op_wr(h); op_wr(d); op_wr(dt); op_wr(mo); op_wr(y);
  endtask

  task automatic exp7(input string req, input logic [7:0] s, m, h, d, dt, mo, y);
    read_all();
    chk(req, "sec", rb[0], s);  chk(req, "min", rb[1], m);
    chk(req, "hour", rb[2], h); chk(req, "dow", rb[3], d);
    chk(req, "date", rb[4], dt); chk(req, "mon", rb[5], mo);
    chk(req, "year", rb[6], y);
  endtask

  task automatic t_reset_r1();
    exp7("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_prescale_r2();
    set7(8'h10, 8'h05, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21);
    tick_n(P - 1);
    read_all(); chk("R2", "sec before period", rb[0], 8'h10);
    tick_n(1);
    read_all(); chk("R2", "sec after period", rb[0], 8'h11);
    tick_n(P / 2);
    op_start(3'd0); op_wr(8'h20);
    tick_n(P - 1);
    read_all(); chk("R2", "sec after restart short", rb[0], 8'h20);
    tick_n(1);
    read_all(); chk("R2", "sec after restart full", rb[0], 8'h21);
  endtask

  task automatic t_min_carry_r3();
    set7(8'h59, 8'h34, 8'h12, 8'h04, 8'h15, 8'h07, 8'h22);
    tick_n(P);
    exp7("R3", 8'h00, 8'h35, 8'h12, 8'h04, 8'h15, 8'h07, 8'h22);
  endtask

  task automatic t_full_roll_r4_r6_r8();
    set7(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    tick_n(P);
    exp7("R4 R6 R8", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h81, 8'h00);
  endtask

  task automatic t_month_len_r7();
    set7(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick_n(P); read_all();
    chk("R7", "leap feb date", rb[4], 8'h29); chk("R7", "leap feb mon", rb[5], 8'h02);
    set7(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick_n(P); read_all();
    chk("R7", "plain feb date", rb[4], 8'h01); chk("R7", "plain feb mon", rb[5], 8'h03);
    set7(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick_n(P); read_all();
    chk("R7", "year00 feb date", rb[4], 8'h29);
    set7(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    tick_n(P); read_all();
    chk("R7", "apr30 date", rb[4], 8'h01); chk("R7", "apr30 mon", rb[5], 8'h05);
  endtask

  task automatic t_12h_r5();
    set7(8'h59, 8'h59, 8'h51, 8'h02, 8'h15, 8'h06, 8'h30);
    tick_n(P); read_all();
    chk("R5", "11AM->12PM", rb[2], 8'h72); chk("R5", "noon no day", rb[3], 8'h02);
    set7(8'h59, 8'h59, 8'h72, 8'h02, 8'h15, 8'h06, 8'h30);
    tick_n(P); read_all();
    chk("R5", "12PM->1PM", rb[2], 8'h61);
    set7(8'h59, 8'h59, 8'h71, 8'h02, 8'h15, 8'h06, 8'h30);
    tick_n(P); read_all();
    chk("R5", "11PM->12AM", rb[2], 8'h52); chk("R5", "midnight dow", rb[3], 8'h03);
    chk("R5", "midnight date", rb[4], 8'h16);
  endtask

  task automatic t_dow_zero_r6();
    op_start(3'd3); op_wr(8'h00);
    read_all(); chk("R6", "dow write 0", rb[3], 8'h01);
  endtask

  task automatic t_ptr_r9();
    logic [7:0] v;
    set7(8'h11, 8'h22, 8'h13, 8'h04, 8'h25, 8'h06, 8'h47);
    op_start(3'd6); op_rd_next(v); chk("R9", "start at year", v, 8'h47);
    op_rd_next(v); chk("R9", "wrap to sec", v, 8'h11);
    op_start(3'd2); op_rd_next(v); chk("R9", "start at hour", v, 8'h13);
  endtask

  task automatic t_snapshot_r10();
    logic [7:0] v;
    set7(8'h59, 8'h10, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21);
    op_start(3'd0);
    op_rd_next(v); chk("R10", "snap sec", v, 8'h59);
    tick_n(P);
    op_rd_next(v); chk("R10", "snap min held", v, 8'h10);
    read_all();
    chk("R10", "fresh sec", rb[0], 8'h00); chk("R10", "fresh min", rb[1], 8'h11);
  endtask

  task automatic t_collide_r11();
    set7(8'h10, 8'h05, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21);
    tick_n(P - 1);
    op_start(3'd0);
    @(negedge clk); ref_tick = 1'b1; wr = 1'b1; wdata = 8'h30;
    @(posedge clk); #1 ref_tick = 1'b0; wr = 1'b0;
    read_all(); chk("R11", "written sec kept", rb[0], 8'h30);
    tick_n(P - 1);
    read_all(); chk("R11", "no early tick", rb[0], 8'h30);
    tick_n(1);
    read_all(); chk("R11", "tick after full period", rb[0], 8'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_prescale_r2();
    t_min_carry_r3();
    t_full_roll_r4_r6_r8();
    t_month_len_r7();
    t_12h_r5();
    t_dow_zero_r6();
    t_ptr_r9();
    t_snapshot_r10();
    t_collide_r11();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule